// File: doc/BRIEF.md
# GPIO Input-Change Interrupt Controller

This block watches the synchronized input vectors of one or two GPIO channels and raises a per-channel event whenever any bit of a channel's inputs changes value. Each event latches a bit in a status register. A per-channel enable register and a single global enable decide whether latched events reach the one interrupt request line. That line is registered, active-high and level-sensitive.

Software reaches the three registers through a simple register port that the block shares with the GPIO data registers. Software reads take effect at once, and writes take effect at the clock edge. Status bits use toggle-on-write semantics: each 1 written inverts the matching bit. The same register can therefore clear a serviced event or inject one for testing. When the interrupt option parameter is off, the registers are absent: they read as zero, they ignore writes, and the request line stays low.

Top module: `gci_irq_ctrl`

## Requirements
- R1: A value change on any bit of channel 1 inputs sets status bit 0 (register at byte offset 0x120), and a change on any bit of channel 2 sets status bit 1, at the clock edge where the changed value is first sampled. Inputs that stay stable raise no event.
- R2: An event sets its status bit even while that channel's enable bit is 0.
- R3: A write to offset 0x120 inverts each of status bits [1:0] whose write-data bit is 1 and leaves the bits written with 0 unchanged. Status bits [31:2] read 0.
- R4: When a hardware event and a toggle write hit the same status bit in the same cycle, the bit ends up 1.
- R5: The enable register at offset 0x128 stores write-data bits [1:0] (bit 0 is channel 1, bit 1 is channel 2) and reads 0 in bits [31:2]. The global enable is bit 31 at offset 0x11C, and bits [30:0] there read 0.
- R6: One cycle after a clock edge, irq_o equals the global enable ANDed with the OR over both channels of (status AND enable).
- R7: While reset is asserted and right after it, irq_o is 0 and all three registers read 0.
- R8: In the first cycle after reset release, no event is raised, even when the inputs differ from zero.
- R9: Any offset other than 0x11C, 0x120 and 0x128 reads 0, and writes to such offsets change no register.
- R10: With the interrupt option parameter at 0, every offset reads 0, writes have no effect and irq_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ch1_in | input | CH1_W | Synchronized channel 1 input vector |
| ch2_in | input | CH2_W | Synchronized channel 2 input vector (ignored in single-channel builds) |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W (9) | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational, zero for offsets this block does not own |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that the channel inputs are already synchronous to clk and that reg_wr, reg_addr and reg_wdata are stable around each rising edge. The bench drives every input at the falling edge, so no input moves near a sampling edge. The checks on toggle and hold also assume that a write lasts exactly one cycle, and the bench's write task drops reg_wr after one cycle. Random phases mix input changes, writes to owned and foreign offsets, and collisions between events and toggle writes. All of this runs while a behavioural model is compared on every clock.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_GIE  = 9'h11C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 9'h120;
  localparam logic [ADDR_W-1:0] OFS_EN   = 9'h128;

  localparam int unsigned GIE_BIT = 31;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_GIE  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_EN   = 2'd3
  } gci_sel_e;

  function automatic gci_sel_e gci_decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_GIE:  return SEL_GIE;
      OFS_STAT: return SEL_STAT;
      OFS_EN:   return SEL_EN;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gci_edge_watch.sv
module gci_edge_watch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic         evt_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= din;
      armed_q <= 1'b1;
    end
  end

  assign evt_o = armed_q && (din != prev_q);

  // R1 / R8: an input vector held since the last edge never flags an event
  assert_steady_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(din) |-> !evt_o);
endmodule

// File: rtl/gci_regs.sv
module gci_regs
  import gci_pkg::*;
#(
  parameter int unsigned DUAL_CH = 1,
  parameter int unsigned IRQ_OPT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        stat_o,
  output logic [1:0]        en_o,
  output logic              gie_o
);
  localparam logic [1:0] CH_MASK = (DUAL_CH != 0) ? 2'b11 : 2'b01;

  gci_sel_e sel;
  assign sel = gci_decode(addr);

  if (IRQ_OPT != 0) begin : g_on
    logic [1:0] stat_q, stat_d, en_q, en_d;
    logic       gie_q, gie_d, upd;
    logic [DATA_W-1:0] unused_wdata;

    assign unused_wdata = wdata;
    assign upd = wr_en || (|(evt_i & CH_MASK));

    always_comb begin
      stat_d = stat_q;
      en_d   = en_q;
      gie_d  = gie_q;
      if (wr_en) begin
        case (sel)
          SEL_STAT: stat_d = stat_q ^ wdata[1:0];
          SEL_EN:   en_d   = wdata[1:0];
          SEL_GIE:  gie_d  = wdata[GIE_BIT];
          default:  ;
        endcase
      end
      stat_d = (stat_d | evt_i) & CH_MASK;
      en_d   = en_d & CH_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q <= '0;
        en_q   <= '0;
        gie_q  <= 1'b0;
      end else if (upd) begin
        stat_q <= stat_d;
        en_q   <= en_d;
        gie_q  <= gie_d;
      end
    end

    always_comb begin
      rdata = '0;
      case (sel)
        SEL_STAT: rdata[1:0]     = stat_q;
        SEL_EN:   rdata[1:0]     = en_q;
        SEL_GIE:  rdata[GIE_BIT] = gie_q;
        default:  rdata = '0;
      endcase
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign gie_o  = gie_q;

    // R2: a hardware event latches regardless of the enable bit
    assert_evt_sets_ch1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[0] |=> stat_q[0]);
    assert_evt_sets_ch2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[1] && DUAL_CH != 0) |=> stat_q[1]);
    // R3: a toggle write without a colliding event inverts exactly the 1 bits
    assert_toggle_ch1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_STAT && !evt_i[0]) |=> (stat_q[0] == $past(stat_q[0] ^ wdata[0])));
    // R3 / R5: no write and no event leaves every register untouched
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && evt_i == 2'b00) |=> ($stable(stat_q) && $stable(en_q) && $stable(gie_q)));
    // R9: writes to foreign offsets change nothing but event bits
    assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_NONE) |=> ($stable(en_q) && $stable(gie_q)));
  end else begin : g_off
    assign rdata  = '0;
    assign stat_o = '0;
    assign en_o   = '0;
    assign gie_o  = 1'b0;
  end
endmodule

// File: rtl/gci_irq_ctrl.sv
module gci_irq_ctrl
  import gci_pkg::*;
#(
  parameter int unsigned CH1_W   = 8,
  parameter int unsigned CH2_W   = 8,
  parameter int unsigned DUAL_CH = 1,
  parameter int unsigned IRQ_OPT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH1_W-1:0]  ch1_in,
  input  logic [CH2_W-1:0]  ch2_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [1:0] evt, stat, en;
  logic       gie, irq_d, irq_q;

  gci_edge_watch #(.W(CH1_W)) i_watch_ch1 (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ch1_in),
    .evt_o (evt[0])
  );

  if (DUAL_CH != 0) begin : g_ch2
    gci_edge_watch #(.W(CH2_W)) i_watch_ch2 (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ch2_in),
      .evt_o (evt[1])
    );
  end else begin : g_no_ch2
    logic [CH2_W-1:0] unused_ch2;
    assign unused_ch2 = ch2_in;
    assign evt[1]     = 1'b0;
  end

  gci_regs #(.DUAL_CH(DUAL_CH), .IRQ_OPT(IRQ_OPT)) i_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .stat_o (stat),
    .en_o   (en),
    .gie_o  (gie)
  );

  always_comb irq_d = gie && (|(stat & en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R6: request follows the masked status one cycle later
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq_o);
  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && (|(stat & en))) |=> irq_o);
  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en) == 2'b00) |=> !irq_o);
endmodule

// File: tb/test_gci_irq_ctrl.sv
module test_gci_irq_ctrl;
  localparam int unsigned W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [W-1:0] ch1 = 8'h5A;
  logic [W-1:0] ch2 = 8'h00;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = 9'h000;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] rdata, rdata_b;
  logic        irq, irq_b;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gci_irq_ctrl i_gci_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ch1_in(ch1), .ch2_in(ch2),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq_o(irq)
  );

  gci_irq_ctrl #(.DUAL_CH(0), .IRQ_OPT(0)) i_gci_irq_ctrl_bare (
    .clk(clk), .rst_n(rst_n), .ch1_in(ch1), .ch2_in(ch2),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_b), .irq_o(irq_b)
  );

  // behavioural reference
  logic [1:0]   m_stat = 2'b00, m_en = 2'b00, evv;
  logic         m_gie = 1'b0, m_irq = 1'b0, m_armed = 1'b0;
  logic [W-1:0] m_p1 = '0, m_p2 = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 2'b00; m_en = 2'b00; m_gie = 1'b0; m_irq = 1'b0;
      m_armed = 1'b0; m_p1 = '0; m_p2 = '0;
    end else begin
      m_irq = m_gie && ((m_stat & m_en) != 2'b00);
      evv = 2'b00;
      if (m_armed && ch1 != m_p1) evv[0] = 1'b1;
      if (m_armed && ch2 != m_p2) evv[1] = 1'b1;
      if (reg_wr && reg_addr == 9'h120) m_stat = m_stat ^ reg_wdata[1:0];
      if (reg_wr && reg_addr == 9'h128) m_en = reg_wdata[1:0];
      if (reg_wr && reg_addr == 9'h11C) m_gie = reg_wdata[31];
      m_stat = m_stat | evv;
      m_p1 = ch1; m_p2 = ch2; m_armed = 1'b1;
    end
  end

  function automatic logic [31:0] m_read(input logic [8:0] a);
    case (a)
      9'h11C:  return {m_gie, 31'b0};
      9'h120:  return {30'b0, m_stat};
      9'h128:  return {30'b0, m_en};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      check(!rst_n ? "R7 irq in reset" : "R6 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      case (reg_addr)
        9'h120:  check("R3 status vs model", rdata, m_read(reg_addr));
        9'h128:  check("R5 enable vs model", rdata, m_read(reg_addr));
        9'h11C:  check("R5 global vs model", rdata, m_read(reg_addr));
        default: check("R9 foreign read vs model", rdata, m_read(reg_addr));
      endcase
      check("R10 bare read", rdata_b, 32'h0);
      check("R10 bare irq", {31'b0, irq_b}, 32'h0);
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(tag, rdata, exp);
  endtask

  task automatic set_in(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    ch1 = a; ch2 = b;
  endtask

  initial begin
    // R7: reset state with nonzero inputs applied
    repeat (3) @(negedge clk);
    reg_addr = 9'h120; #2; check("R7 status in reset", rdata, 32'h0);
    reg_addr = 9'h128; #1; check("R7 enable in reset", rdata, 32'h0);
    reg_addr = 9'h11C; #1; check("R7 global in reset", rdata, 32'h0);
    check("R7 irq in reset", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_rd("R8 no event after release", 9'h120, 32'h0);
    check("R7 irq after release", {31'b0, irq}, 32'h0);

    set_in(8'h52, 8'h00);                       // one bit of channel 1 flips
    expect_rd("R1 ch1 change sets bit0", 9'h120, 32'h1);
    check("R2 irq low with enables off", {31'b0, irq}, 32'h0);
    expect_rd("R2 bit0 latched while disabled", 9'h120, 32'h1);

    wr(9'h128, 32'hFFFF_FFFF);
    expect_rd("R5 enable keeps bits 1:0", 9'h128, 32'h3);
    check("R6 irq low without global", {31'b0, irq}, 32'h0);
    wr(9'h11C, 32'h8000_0001);
    expect_rd("R5 global bit31 only", 9'h11C, 32'h8000_0000);
    check("R6 irq raised", {31'b0, irq}, 32'h1);

    wr(9'h120, 32'hFFFF_FFFC);
    expect_rd("R3 zero bits leave status", 9'h120, 32'h1);
    wr(9'h120, 32'h1);
    expect_rd("R3 one bit clears status", 9'h120, 32'h0);
    check("R6 irq dropped", {31'b0, irq}, 32'h0);
    wr(9'h120, 32'h1);
    expect_rd("R3 one bit sets cleared status", 9'h120, 32'h1);
    wr(9'h120, 32'h1);

    set_in(8'h52, 8'h80);
    expect_rd("R1 ch2 change sets bit1", 9'h120, 32'h2);
    set_in(8'h52, 8'hFF);                       // several bits at once
    @(negedge clk);
    ch2 = 8'h7E; reg_wr = 1'b1; reg_addr = 9'h120; reg_wdata = 32'h2;
    @(negedge clk); reg_wr = 1'b0;
    expect_rd("R4 event beats toggle", 9'h120, 32'h2);

    wr(9'h124, 32'hFFFF_FFFF);
    wr(9'h000, 32'h0);
    expect_rd("R9 foreign offset reads zero", 9'h124, 32'h0);
    expect_rd("R9 enable untouched", 9'h128, 32'h3);
    expect_rd("R9 global untouched", 9'h11C, 32'h8000_0000);
    expect_rd("R9 status untouched", 9'h120, 32'h2);

    wr(9'h11C, 32'h0);
    @(negedge clk); #2;
    check("R6 irq off by global", {31'b0, irq}, 32'h0);

    // random phase under per-clock model comparison
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) ch1 = ch1 ^ (8'h1 << $urandom_range(0, 7));
      if ($urandom_range(0, 5) == 0) ch2 = ch2 ^ 8'(1 << $urandom_range(0, 7));
      case ($urandom_range(0, 5))
        0: reg_addr = 9'h11C;
        1: reg_addr = 9'h120;
        2: reg_addr = 9'h128;
        3: reg_addr = 9'h124;
        4: reg_addr = 9'h000;
        default: reg_addr = 9'h120;
      endcase
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom;
    end
    @(negedge clk); reg_wr = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule